// File: doc/BRIEF.md
# Asymmetric Handshake Line Deglitcher

This block cleans up the two handshake strobes of a parallel peripheral bus: the request line (channel 0) and the acknowledge line (channel 1). Both strobes are active-low and reach the block already synchronised to the sampling clock. Each one is filtered on its own path.

A falling edge is an assertion. It goes straight to the registered output and gets no extra delay. A rising edge is a deassertion, and it is treated as a possible glitch. The output follows it only after the raw line has stayed high for a whole filter window, counted in sampling clock cycles. A single control bit chooses the window: the short one, or the extended one used for slow, noisy buses.

The extended window would swallow real short cycles in fast transfer mode. For this reason the block raises a mode-conflict flag whenever the extended window is selected while the fast-mode indicator is active.

Top module: `hs_deglitch`

## Requirements
- R1: During reset and on the first cycle after it, every filtered output is high (deasserted), the mode-conflict flag is low and the extend bit is clear.
- R2: A low level on a raw line at a clock edge drives that channel's filtered output low right after that edge (one register stage, no filter delay).
- R3: With the extend bit clear, a low filtered output goes high only after SHORT_WIN consecutive high samples of its raw line. It goes high right after the edge of the SHORT_WIN-th sample. A high pulse of SHORT_WIN-1 samples leaves the output low.
- R4: With the extend bit set, the same rule holds with LONG_WIN samples: a pulse of LONG_WIN-1 high samples is ignored, and one of LONG_WIN samples releases the output.
- R5: Any low sample inside a pending window restarts the count. Two high pulses that together exceed the window but are split by a low sample do not release the output.
- R6: The channels are independent. Activity on one raw line never changes the other channel's filtered output.
- R7: The mode-conflict flag is high exactly in the cycle after an edge where the extend bit and the fast-mode input were both high.
- R8: The extend bit takes cfg_ext at an edge where cfg_we is high and holds its value at every other edge, whatever cfg_ext does. The window in use at an edge is the extend bit's value before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the extend bit |
| cfg_ext | input | 1 | New extend bit value (1 selects LONG_WIN) |
| fast_mode | input | 1 | High while fast transfer mode is active |
| hs_n_i | input | NUM_CH | Synchronised raw active-low strobes, bit 0 request, bit 1 acknowledge |
| hs_n_o | output | NUM_CH | Filtered active-low strobes |
| mode_conflict | output | 1 | Extended window selected during fast mode |

## Verification
The hardest case is the exact window boundary under the extended setting. To reach it, the stimulus first writes the extend bit, then pulls cfg_ext back low without a write strobe, and then sends high pulses exactly one sample shorter and one sample longer than each window. A release one cycle early or late shows up only in those pulses. Split pulses, a low sample dropped between two high runs, exercise the counter restart. Toggling one strobe while the other is held low exposes any sharing between the channels.

// File: rtl/hs_dg_pkg.sv
`timescale 1ns/1ps
package hs_dg_pkg;

    // width of every run-length counter in the block
    localparam int RUN_W = 8;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    typedef logic [RUN_W-1:0] run_t;

    // per-channel filter state
    typedef struct packed {
        logic line_n;   // filtered active-low level
        run_t run;      // consecutive high samples while output is low
    } chan_st_t;

    // configuration state
    typedef struct packed {
        logic ext;       // extended deassert window selected
        logic conflict;  // extended window during fast mode
    } cfg_st_t;

    function automatic run_t run_inc(input run_t r);
        return (r == RUN_MAX) ? r : r + 1'b1;
    endfunction

    function automatic run_t pick_window(input logic ext, input run_t short_w, input run_t long_w);
        return ext ? long_w : short_w;
    endfunction

endpackage

// File: rtl/hs_dg_cfg.sv
`timescale 1ns/1ps
module hs_dg_cfg
    import hs_dg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_we,
    input  logic cfg_ext,
    input  logic fast_mode,
    output logic ext_q,
    output logic conflict_q
);

    cfg_st_t st_q, st_d;

    always_comb begin
        st_d          = st_q;
        st_d.conflict = st_q.ext & fast_mode;
        if (cfg_we) begin
            st_d.ext = cfg_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ext_q      = st_q.ext;
    assign conflict_q = st_q.conflict;

endmodule

// File: rtl/hs_dg_chan.sv
`timescale 1ns/1ps
module hs_dg_chan
    import hs_dg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raw_n,
    input  run_t win,
    output logic filt_n
);

    chan_st_t st_q, st_d;
    run_t     run_nx;

    assign run_nx = run_inc(st_q.run);

    always_comb begin
        st_d = st_q;
        if (!raw_n) begin
            // assertion passes at once and restarts any pending window
            st_d.line_n = 1'b0;
            st_d.run    = '0;
        end else if (!st_q.line_n) begin
            if (run_nx >= win) begin
                st_d.line_n = 1'b1;
                st_d.run    = '0;
            end else begin
                st_d.run = run_nx;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.line_n <= 1'b1;
            st_q.run    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_n = st_q.line_n;

endmodule

// File: rtl/hs_deglitch.sv
`timescale 1ns/1ps
module hs_deglitch
    import hs_dg_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int SHORT_WIN = 3,
    parameter int LONG_WIN  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_ext,
    input  logic              fast_mode,
    input  logic [NUM_CH-1:0] hs_n_i,
    output logic [NUM_CH-1:0] hs_n_o,
    output logic              mode_conflict
);

    localparam run_t SHORT_R = run_t'(SHORT_WIN);
    localparam run_t LONG_R  = run_t'(LONG_WIN);

    logic ext_q;
    run_t win_sel;

    hs_dg_cfg i_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_ext    (cfg_ext),
        .fast_mode  (fast_mode),
        .ext_q      (ext_q),
        .conflict_q (mode_conflict)
    );

    assign win_sel = pick_window(ext_q, SHORT_R, LONG_R);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        hs_dg_chan i_chan (
            .clk    (clk),
            .rst    (rst),
            .raw_n  (hs_n_i[g]),
            .win    (win_sel),
            .filt_n (hs_n_o[g])
        );
    end

endmodule

// File: rtl/hs_deglitch_chk.sv
`timescale 1ns/1ps
module hs_deglitch_chk #(
    parameter int NUM_CH    = 2,
    parameter int SHORT_WIN = 3,
    parameter int LONG_WIN  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              fast_mode,
    input logic [NUM_CH-1:0] hs_n_i,
    input logic [NUM_CH-1:0] hs_n_o,
    input logic              mode_conflict,
    input logic              ext_q
);

    localparam logic [7:0] SW = 8'(SHORT_WIN);
    localparam logic [7:0] LW = 8'(LONG_WIN);

    logic [7:0] win_now;
    assign win_now = ext_q ? LW : SW;

    AST_RESET_OUT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&hs_n_o) && !mode_conflict && !ext_q); // R1

    AST_CONFLICT: assert property (@(posedge clk) disable iff (rst)
        mode_conflict == ($past(ext_q) && $past(fast_mode))); // R7

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_we) |-> $stable(ext_q)); // R8

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        logic [7:0] run;

        always_ff @(posedge clk) begin
            if (rst || !hs_n_i[g]) begin
                run <= '0;
            end else if (run < LW) begin
                run <= run + 8'd1;
            end
        end

        AST_ASSERT_PASS: assert property (@(posedge clk) disable iff (rst)
            !hs_n_i[g] |=> !hs_n_o[g]); // R2

        AST_SHORT_WINDOW: assert property (@(posedge clk) disable iff (rst)
            $rose(hs_n_o[g]) |-> run >= SW); // R3

        AST_LONG_WINDOW: assert property (@(posedge clk) disable iff (rst)
            $rose(hs_n_o[g]) && $past(ext_q) |-> run >= LW); // R4

        AST_RELEASE_DUE: assert property (@(posedge clk) disable iff (rst)
            hs_n_i[g] && !hs_n_o[g] && (run + 8'd1 >= win_now) |=> hs_n_o[g]); // R5
    end

endmodule

bind hs_deglitch hs_deglitch_chk #(
    .NUM_CH    (NUM_CH),
    .SHORT_WIN (SHORT_WIN),
    .LONG_WIN  (LONG_WIN)
) i_hs_deglitch_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_we        (cfg_we),
    .fast_mode     (fast_mode),
    .hs_n_i        (hs_n_i),
    .hs_n_o        (hs_n_o),
    .mode_conflict (mode_conflict),
    .ext_q         (ext_q)
);

// File: tb/test_hs_deglitch.sv
`timescale 1ns/1ps
module test_hs_deglitch;

    localparam int NUM_CH    = 2;
    localparam int SHORT_WIN = 3;
    localparam int LONG_WIN  = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic              cfg_ext = 1'b0;
    logic              fast_mode = 1'b0;
    logic [NUM_CH-1:0] hs_n_i = '1;
    logic [NUM_CH-1:0] hs_n_o;
    logic              mode_conflict;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // scoreboard queues, one entry per clock edge
    logic [NUM_CH-1:0] q_line[$];
    logic              q_err[$];
    string             q_tag[$];

    // reference state built from the requirements
    logic [NUM_CH-1:0] m_out = '1;
    int                m_run[NUM_CH];
    logic              m_ext = 1'b0;
    logic              cur_fast = 1'b0;

    hs_deglitch #(
        .NUM_CH    (NUM_CH),
        .SHORT_WIN (SHORT_WIN),
        .LONG_WIN  (LONG_WIN)
    ) i_hs_deglitch (
        .clk           (clk),
        .rst           (rst),
        .cfg_we        (cfg_we),
        .cfg_ext       (cfg_ext),
        .fast_mode     (fast_mode),
        .hs_n_i        (hs_n_i),
        .hs_n_o        (hs_n_o),
        .mode_conflict (mode_conflict)
    );

    always #2.5 clk = ~clk;

    // driver: one stimulus step per cycle, expected result pushed for the next edge
    task automatic step(input logic [NUM_CH-1:0] lines, input logic we, input logic ext_d, input string tag);
        int win;
        @(negedge clk);
        hs_n_i    = lines;
        fast_mode = cur_fast;
        cfg_we    = we;
        cfg_ext   = ext_d;
        win = m_ext ? LONG_WIN : SHORT_WIN;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (!lines[ch]) begin
                m_run[ch] = 0;
                m_out[ch] = 1'b0;
            end else begin
                if (m_run[ch] < 100) m_run[ch]++;
                if (!m_out[ch] && m_run[ch] >= win) m_out[ch] = 1'b1;
            end
        end
        q_line.push_back(m_out);
        q_err.push_back(m_ext && cur_fast);
        q_tag.push_back(tag);
        if (we) m_ext = ext_d;
    endtask

    task automatic hold(input logic [NUM_CH-1:0] lines, input int n, input string tag);
        for (int i = 0; i < n; i++) step(lines, 1'b0, 1'b0, tag);
    endtask

    task automatic wr_ext(input logic v, input string tag);
        step(hs_n_i, 1'b1, v, tag);
    endtask

    // monitor: compares every cycle away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_line.size() > 0) begin
                logic [NUM_CH-1:0] el;
                logic              ee;
                string             et;
                el = q_line.pop_front();
                ee = q_err.pop_front();
                et = q_tag.pop_front();
                checks++;
                if (hs_n_o !== el || mode_conflict !== ee) begin
                    errors++;
                    $display("FAIL %s: hs_n_o=%b mode_conflict=%b, expected hs_n_o=%b mode_conflict=%b at %0t",
                             et, hs_n_o, mode_conflict, el, ee, $time);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int ch = 0; ch < NUM_CH; ch++) m_run[ch] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state visible during reset
        checks++;
        if (hs_n_o !== '1 || mode_conflict !== 1'b0) begin
            errors++;
            $display("FAIL R1: hs_n_o=%b mode_conflict=%b, expected 11 0", hs_n_o, mode_conflict);
        end
        rst = 1'b0;
        hold(2'b11, 3, "R1");

        // R2: assertion goes straight through on request
        hold(2'b10, 2, "R2");

        // R3: short window boundary on request
        hold(2'b11, SHORT_WIN - 1, "R3");
        hold(2'b10, 2, "R3");
        hold(2'b11, SHORT_WIN, "R3");
        hold(2'b11, 2, "R3");

        // R5: split pulses restart the count
        hold(2'b10, 2, "R5");
        hold(2'b11, 2, "R5");
        hold(2'b10, 1, "R5");
        hold(2'b11, 2, "R5");
        hold(2'b10, 1, "R5");
        hold(2'b11, SHORT_WIN + 1, "R5");

        // R6: acknowledge filtered on its own while request stays high
        hold(2'b01, 3, "R6");
        hold(2'b11, SHORT_WIN - 1, "R6");
        hold(2'b01, 1, "R6");
        hold(2'b00, 2, "R6");
        hold(2'b10, SHORT_WIN + 1, "R6");
        hold(2'b11, SHORT_WIN + 1, "R6");

        // R8: write extend bit, then cfg_ext low without strobe
        wr_ext(1'b1, "R8");
        hold(2'b10, 2, "R8");
        hold(2'b11, SHORT_WIN, "R8");
        hold(2'b10, 1, "R8");

        // R4: long window boundary on both channels
        hold(2'b00, 2, "R4");
        hold(2'b11, LONG_WIN - 1, "R4");
        hold(2'b00, 2, "R4");
        hold(2'b11, LONG_WIN, "R4");
        hold(2'b11, 2, "R4");

        // R7: conflict flag
        cur_fast = 1'b1;
        hold(2'b11, 3, "R7");
        wr_ext(1'b0, "R7");
        hold(2'b11, 3, "R7");
        cur_fast = 1'b0;
        wr_ext(1'b1, "R7");
        hold(2'b11, 2, "R7");
        wr_ext(1'b0, "R7");

        // R3 again under fast mode with short window
        cur_fast = 1'b1;
        hold(2'b10, 2, "R3");
        hold(2'b11, SHORT_WIN - 1, "R3");
        hold(2'b10, 1, "R3");
        hold(2'b11, SHORT_WIN + 1, "R3");
        cur_fast = 1'b0;
        hold(2'b11, 2, "R3");

        while (q_line.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule